// File: doc/BRIEF.md
# Wishbone Multi-Master Crossbar

This block joins a set of Wishbone classic masters to a set of Wishbone classic slaves so that masters reaching different slaves proceed at the same time. Each master's address is compared against an inclusive lower and upper bound for every slave. Every slave port has its own arbiter, and that arbiter chooses among the masters that currently address it. The request of the chosen master passes to the slave without a register stage. The slave's acknowledge and read data return only to that master.

A slave port that no master holds drives all of its request outputs to zero. A master that holds no path to a slave sees ACK low and read data zero. A grant stays with its master for the whole bus cycle, meaning as long as that master keeps CYC high. The grant is freed on the clock edge that samples CYC low. Both port counts may be set up to 32. The default build has two masters and four slaves, with windows at 0x0000_0000, 0x0000_1000, 0x0000_2000 and 0x0000_3000, each 4 KiB long.

Top module: `wb_xbar`

## Requirements
- R1: Master m addresses slave k only when its CYC and STB are both high and lo[k] <= ADR <= hi[k]. Both bounds count as inside the window.
- R2: A master whose ADR lies in no window is granted no slave. It sees ACK low and read data zero, and no slave STB rises on its behalf.
- R3: When an unheld slave is addressed by several masters in the same cycle, the lowest-numbered master wins. It is served in that same cycle.
- R4: Once a master wins a slave, it keeps that slave while its CYC stays high, even when its STB is low. No other master reaches that slave during that time.
- R5: The grant is freed at the clock edge where the holder's CYC is low. A waiting master is served in the next cycle, but not in the cycle where the holder drops CYC.
- R6: The held slave sees the holder's ADR, write data, SEL, WE and CYC combinationally in the same cycle. Its STB is high only while the holder addresses that slave.
- R7: A master receives ACK and read data only from the slave it holds and currently addresses. In every other case it sees ACK 0 and data 0.
- R8: A slave port held by no master drives CYC, STB and WE low, and drives ADR, write data and SEL to zero.
- R9: Synchronous active-low reset frees every grant. With idle masters during and after reset, all slave CYC/STB and all master ACK are low.
- R10: If windows overlap, an address that falls in several windows selects only the lowest-numbered slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| m_adr_i | input | NM*AW | Master addresses, master m at bits [m*AW +: AW] |
| m_dat_i | input | NM*DW | Master write data |
| m_sel_i | input | NM*SW | Master byte selects (SW = DW/8) |
| m_we_i | input | NM | Master write enables |
| m_cyc_i | input | NM | Master bus-cycle flags |
| m_stb_i | input | NM | Master strobes |
| m_ack_o | output | NM | Acknowledge to each master |
| m_dat_o | output | NM*DW | Read data to each master |
| s_adr_o | output | NS*AW | Address to each slave |
| s_dat_o | output | NS*DW | Write data to each slave |
| s_sel_o | output | NS*SW | Byte selects to each slave |
| s_we_o | output | NS | Write enable to each slave |
| s_cyc_o | output | NS | Bus-cycle flag to each slave |
| s_stb_o | output | NS | Strobe to each slave |
| s_ack_i | input | NS | Acknowledge from each slave |
| s_dat_i | input | NS*DW | Read data from each slave |
| win_lo_i | input | NS*AW | Inclusive lower bound of each slave window |
| win_hi_i | input | NS*AW | Inclusive upper bound of each slave window |

## Verification
The hardest case to reach from the ports is a loser kept waiting across a held grant. One master must win a slave and then keep CYC high with STB low. The second master must meanwhile strobe the same slave, and then the holder must release. Random traffic seldom builds that overlap, so a directed sequence sets it up one cycle at a time. It checks that the waiting master gets nothing both while the holder idles and in the cycle where the holder drops CYC, and that it is served one cycle later.

The random phase drives the interval bounds and the addresses just past them, as well as unmapped addresses. It also varies slave acknowledges and sometimes moves a holder to another slave in mid-cycle. A directed step with overlapping windows covers the priority of the lowest-numbered slave.

// File: rtl/wbx_pkg.sv
// Shared definitions for the crossbar: the arbiter's hold state.
package wbx_pkg;

    // Arbiter hold state: free to pick, or kept by the current owner.
    typedef enum logic {
        ARB_FREE = 1'b0,
        ARB_HELD = 1'b1
    } arb_state_e;

endpackage

// File: rtl/wbx_addr_decode.sv
// Address decoder for one master.
// Compares the master address against every slave window. Both bounds
// count as inside the window. A hit is reported only while CYC and STB
// are high. If windows overlap, only the lowest-numbered slave hits, so
// hit_o is one-hot or zero.
// Assumes lo_i/hi_i are stable while a cycle is in progress.
module wbx_addr_decode #(
    parameter int unsigned NS = 4,
    parameter int unsigned AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   adr_i,
    input  logic            cyc_i,
    input  logic            stb_i,
    input  logic [NS*AW-1:0] lo_i,
    input  logic [NS*AW-1:0] hi_i,
    output logic [NS-1:0]   hit_o
);

    logic [NS-1:0] in_win;
    logic [NS-1:0] raw;

    // Compare the address against each window.
    always_comb begin
        for (int k = 0; k < NS; k++) begin
            in_win[k] = (adr_i >= lo_i[k*AW +: AW]) && (adr_i <= hi_i[k*AW +: AW]);
        end
    end

    // Gate the matches with the strobe, then keep only the lowest slave.
    always_comb begin
        raw   = (cyc_i && stb_i) ? in_win : '0;
        hit_o = raw & (~raw + NS'(1));
    end

    // R10: at most one slave is selected per master.
    p_hit_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_o));

    // R1: a selection needs both CYC and STB.
    p_hit_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o != '0) |-> (cyc_i && stb_i));

endmodule

// File: rtl/wbx_slave_arb.sv
// Arbiter for one slave port.
// A free arbiter grants the lowest-numbered requesting master in the same
// cycle and then holds that master. The hold ends at the clock edge that
// samples the owner's CYC low. The grant is one-hot or zero.
// Assumes req_i bit m is master m's decoded hit for this slave.
module wbx_slave_arb
    import wbx_pkg::*;
#(
    parameter int unsigned NM = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NM-1:0] req_i,
    input  logic [NM-1:0] cyc_i,
    output logic [NM-1:0] gnt_o
);

    arb_state_e    state_q;
    logic [NM-1:0] owner_q;
    logic [NM-1:0] pick;
    logic          owner_live;

    // Lowest-numbered requester, used only while free.
    always_comb begin
        pick       = req_i & (~req_i + NM'(1));
        owner_live = |(owner_q & cyc_i);
        gnt_o      = (state_q == ARB_HELD) ? owner_q : pick;
    end

    // Hold or free the slave, and track the owner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_FREE;
            owner_q <= '0;
        end else if (state_q == ARB_HELD) begin
            if (!owner_live) begin
                state_q <= ARB_FREE;
                owner_q <= '0;
            end
        end else if (pick != '0) begin
            state_q <= ARB_HELD;
            owner_q <= pick;
        end
    end

    // R3: never more than one master granted.
    p_gnt_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    // R4: a live owner keeps the slave across the edge.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_HELD && owner_live) |=>
        (state_q == ARB_HELD && owner_q == $past(owner_q)));

    // R5: an owner with CYC low frees the slave at the next edge.
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_HELD && !owner_live) |=> (state_q == ARB_FREE));

endmodule

// File: rtl/wbx_onehot_mux.sv
// AND-OR multiplexer with a one-hot select.
// The output is zero when no select bit is set. Assumes sel_i is one-hot
// or zero; with several bits set the selected inputs are ORed together.
module wbx_onehot_mux #(
    parameter int unsigned N = 2,
    parameter int unsigned W = 32
) (
    input  logic [N-1:0]   sel_i,
    input  logic [N*W-1:0] din_i,
    output logic [W-1:0]   dout_o
);

    // Combine the selected lanes.
    always_comb begin
        dout_o = '0;
        for (int i = 0; i < N; i++) begin
            if (sel_i[i]) dout_o = dout_o | din_i[i*W +: W];
        end
    end

endmodule

// File: rtl/wb_xbar.sv
// Wishbone classic crossbar, NM masters by NS slaves.
// Each master has a window decoder, and each slave has a holding arbiter.
// Requests pass from the holder to the slave combinationally. Responses
// return through a one-hot path equal to (grant AND current hit). Ports not
// in use are driven to zero.
// Assumes NM and NS are at most 32 and that masters keep their slave for
// the whole CYC period.
module wb_xbar #(
    parameter  int unsigned NM = 2,
    parameter  int unsigned NS = 4,
    parameter  int unsigned AW = 32,
    parameter  int unsigned DW = 32,
    localparam int unsigned SW = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NM*AW-1:0] m_adr_i,
    input  logic [NM*DW-1:0] m_dat_i,
    input  logic [NM*SW-1:0] m_sel_i,
    input  logic [NM-1:0]    m_we_i,
    input  logic [NM-1:0]    m_cyc_i,
    input  logic [NM-1:0]    m_stb_i,
    output logic [NM-1:0]    m_ack_o,
    output logic [NM*DW-1:0] m_dat_o,
    output logic [NS*AW-1:0] s_adr_o,
    output logic [NS*DW-1:0] s_dat_o,
    output logic [NS*SW-1:0] s_sel_o,
    output logic [NS-1:0]    s_we_o,
    output logic [NS-1:0]    s_cyc_o,
    output logic [NS-1:0]    s_stb_o,
    input  logic [NS-1:0]    s_ack_i,
    input  logic [NS*DW-1:0] s_dat_i,
    input  logic [NS*AW-1:0] win_lo_i,
    input  logic [NS*AW-1:0] win_hi_i
);

    logic [NS-1:0] hit    [NM];
    logic [NM-1:0] want   [NS];
    logic [NM-1:0] gnt    [NS];
    logic [NM-1:0] path_s [NS];
    logic [NS-1:0] path_m [NM];

    // Per-master address decode.
    for (genvar m = 0; m < NM; m++) begin : g_dec
        wbx_addr_decode #(.NS(NS), .AW(AW)) u_dec (
            .clk   (clk),
            .rst_n (rst_n),
            .adr_i (m_adr_i[m*AW +: AW]),
            .cyc_i (m_cyc_i[m]),
            .stb_i (m_stb_i[m]),
            .lo_i  (win_lo_i),
            .hi_i  (win_hi_i),
            .hit_o (hit[m])
        );
    end

    // Transpose hits into per-slave requests and build the response paths.
    always_comb begin
        for (int k = 0; k < NS; k++) begin
            for (int m = 0; m < NM; m++) begin
                want[k][m]   = hit[m][k];
                path_s[k][m] = gnt[k][m] & hit[m][k];
                path_m[m][k] = gnt[k][m] & hit[m][k];
            end
        end
    end

    // Per-slave arbiter and request forwarding.
    for (genvar k = 0; k < NS; k++) begin : g_slv
        wbx_slave_arb #(.NM(NM)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req_i (want[k]),
            .cyc_i (m_cyc_i),
            .gnt_o (gnt[k])
        );

        wbx_onehot_mux #(.N(NM), .W(AW)) u_adr (
            .sel_i (gnt[k]), .din_i (m_adr_i), .dout_o (s_adr_o[k*AW +: AW]));
        wbx_onehot_mux #(.N(NM), .W(DW)) u_wdat (
            .sel_i (gnt[k]), .din_i (m_dat_i), .dout_o (s_dat_o[k*DW +: DW]));
        wbx_onehot_mux #(.N(NM), .W(SW)) u_sel (
            .sel_i (gnt[k]), .din_i (m_sel_i), .dout_o (s_sel_o[k*SW +: SW]));
        wbx_onehot_mux #(.N(NM), .W(1)) u_we (
            .sel_i (gnt[k]), .din_i (m_we_i), .dout_o (s_we_o[k +: 1]));

        assign s_cyc_o[k] = |(gnt[k] & m_cyc_i);
        assign s_stb_o[k] = |path_s[k];

        // R8: a slave nobody holds sees no cycle and no write.
        p_idle_slave_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[k] == '0) |-> (!s_cyc_o[k] && !s_we_o[k] && s_adr_o[k*AW +: AW] == '0));

        // R6: a strobe to a slave always sits inside a cycle.
        p_stb_in_cyc_r6: assert property (@(posedge clk) disable iff (!rst_n)
            s_stb_o[k] |-> s_cyc_o[k]);
    end

    // Per-master response steering.
    for (genvar m = 0; m < NM; m++) begin : g_rsp
        wbx_onehot_mux #(.N(NS), .W(DW)) u_rdat (
            .sel_i (path_m[m]), .din_i (s_dat_i), .dout_o (m_dat_o[m*DW +: DW]));

        assign m_ack_o[m] = |(path_m[m] & s_ack_i);

        // R7: an acknowledge only reaches a master that is strobing.
        p_ack_needs_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
            m_ack_o[m] |-> (m_cyc_i[m] && m_stb_i[m]));
    end

endmodule

// File: tb/test_wb_xbar.sv
// Bench for wb_xbar: directed corner cases plus seeded random traffic,
// checked against a requirement-level model of decode, hold and steering.
module test_wb_xbar;

    localparam int NM = 2;
    localparam int NS = 4;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = DW / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NM*AW-1:0] m_adr;
    logic [NM*DW-1:0] m_dat;
    logic [NM*SW-1:0] m_sel;
    logic [NM-1:0]    m_we, m_cyc, m_stb, m_ack;
    logic [NM*DW-1:0] m_rdat;
    logic [NS*AW-1:0] s_adr, w_lo, w_hi;
    logic [NS*DW-1:0] s_wdat, s_rdat;
    logic [NS*SW-1:0] s_sel;
    logic [NS-1:0]    s_we, s_cyc, s_stb, s_ack;

    // Next-cycle stimulus, applied at the falling edge.
    logic [AW-1:0] n_adr [NM];
    logic [DW-1:0] n_dat [NM];
    logic [SW-1:0] n_sel [NM];
    logic          n_we  [NM];
    logic          n_cyc [NM];
    logic          n_stb [NM];
    logic [AW-1:0] lo [NS];
    logic [AW-1:0] hi [NS];
    logic [NS-1:0] ack_en;

    int checks = 0;
    int errors = 0;
    bit lk  [NS];
    int own [NS];
    logic [NM-1:0] seen_ack;
    logic [NS-1:0] seen_stb;

    function automatic logic [DW-1:0] sdata(int k, logic [AW-1:0] a);
        return {8'hA5, 4'(k), 4'h0, a[15:0]};
    endfunction

    // Slave models: acknowledge when strobed and enabled.
    for (genvar k = 0; k < NS; k++) begin : g_slave
        assign s_ack[k] = s_stb[k] & ack_en[k];
        assign s_rdat[k*DW +: DW] = sdata(k, s_adr[k*AW +: AW]);
    end

    wb_xbar #(.NM(NM), .NS(NS), .AW(AW), .DW(DW)) i_wb_xbar (
        .clk(clk), .rst_n(rst_n),
        .m_adr_i(m_adr), .m_dat_i(m_dat), .m_sel_i(m_sel), .m_we_i(m_we),
        .m_cyc_i(m_cyc), .m_stb_i(m_stb), .m_ack_o(m_ack), .m_dat_o(m_rdat),
        .s_adr_o(s_adr), .s_dat_o(s_wdat), .s_sel_o(s_sel), .s_we_o(s_we),
        .s_cyc_o(s_cyc), .s_stb_o(s_stb), .s_ack_i(s_ack), .s_dat_i(s_rdat),
        .win_lo_i(w_lo), .win_hi_i(w_hi));

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Window index for master m per R1/R10, or -1.
    function automatic int exp_hit(int m);
        if (!(n_cyc[m] && n_stb[m])) return -1;
        for (int k = 0; k < NS; k++)
            if (n_adr[m] >= lo[k] && n_adr[m] <= hi[k]) return k;
        return -1;
    endfunction

    // One cycle: apply, compare all outputs with the model, advance model.
    task automatic step();
        int h [NM];
        int g [NS];
        @(negedge clk);
        for (int m = 0; m < NM; m++) begin
            m_adr[m*AW +: AW] = n_adr[m];
            m_dat[m*DW +: DW] = n_dat[m];
            m_sel[m*SW +: SW] = n_sel[m];
            m_we[m] = n_we[m]; m_cyc[m] = n_cyc[m]; m_stb[m] = n_stb[m];
        end
        for (int k = 0; k < NS; k++) begin
            w_lo[k*AW +: AW] = lo[k];
            w_hi[k*AW +: AW] = hi[k];
        end
        #1;
        seen_ack = m_ack;
        seen_stb = s_stb;
        for (int m = 0; m < NM; m++) h[m] = exp_hit(m);
        for (int k = 0; k < NS; k++) begin
            logic [127:0] e;
            g[k] = -1;
            if (rst_n && lk[k]) g[k] = own[k];
            else for (int m = NM - 1; m >= 0; m--) if (h[m] == k) g[k] = m;
            e = '0;
            if (g[k] >= 0)
                e = {1'b0, n_cyc[g[k]], h[g[k]] == k, n_we[g[k]], n_sel[g[k]],
                     n_adr[g[k]], n_dat[g[k]], 56'd0};
            chk(g[k] >= 0 ? "R6 slave request" : "R8 idle slave",
                {1'b0, s_cyc[k], s_stb[k], s_we[k], s_sel[k*SW +: SW],
                 s_adr[k*AW +: AW], s_wdat[k*DW +: DW], 56'd0}, e);
        end
        for (int m = 0; m < NM; m++) begin
            logic [127:0] e;
            e = '0;
            if (h[m] >= 0 && g[h[m]] == m)
                e = {95'd0, ack_en[h[m]], sdata(h[m], n_adr[m])};
            chk("R7 response", {95'd0, m_ack[m], m_rdat[m*DW +: DW]}, e);
        end
        @(posedge clk);
        for (int k = 0; k < NS; k++) begin
            if (!rst_n) lk[k] = 1'b0;
            else if (lk[k]) begin if (!n_cyc[own[k]]) lk[k] = 1'b0; end
            else if (g[k] >= 0) begin lk[k] = 1'b1; own[k] = g[k]; end
        end
    endtask

    task automatic idle_all();
        for (int m = 0; m < NM; m++) begin
            n_cyc[m] = 1'b0; n_stb[m] = 1'b0; n_we[m] = 1'b0;
            n_adr[m] = '0; n_dat[m] = '0; n_sel[m] = '0;
        end
    endtask

    task automatic req(int m, logic [AW-1:0] a);
        n_cyc[m] = 1'b1; n_stb[m] = 1'b1; n_adr[m] = a;
        n_dat[m] = 32'h1000_0000 + a; n_sel[m] = 4'hF; n_we[m] = 1'(m);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < NS; k++) begin
            lo[k] = AW'(k * 32'h1000); hi[k] = AW'(k * 32'h1000 + 32'hFFF);
            lk[k] = 1'b0; own[k] = 0;
        end
        ack_en = '1;
        idle_all();
        // R9: reset with idle masters.
        repeat (3) step();
        chk("R9 reset slave cyc", 128'(s_cyc), 128'd0);
        chk("R9 reset master ack", 128'(seen_ack), 128'd0);
        rst_n = 1'b1;
        step();
        chk("R9 after reset stb", 128'(seen_stb), 128'd0);
        // R1: upper bound of window 1, then lower bound of window 2.
        req(0, 32'h0000_1FFF); step();
        chk("R1 upper bound", {seen_stb, seen_ack}, {4'b0010, 2'b01});
        req(0, 32'h0000_2000); step();
        chk("R1 lower bound", {seen_stb, seen_ack}, {4'b0100, 2'b01});
        idle_all(); step();
        // R2: unmapped address.
        req(0, 32'h0000_4000); step();
        chk("R2 unmapped", {seen_stb, seen_ack}, {4'b0000, 2'b00});
        idle_all(); step();
        // R3: simultaneous requests, master 0 wins.
        req(0, 32'h0000_3010); req(1, 32'h0000_3020); step();
        chk("R3 priority", {seen_stb, seen_ack}, {4'b1000, 2'b01});
        // R4: holder idles with CYC high, master 1 still waits.
        step();
        chk("R4 hold", 128'(seen_ack), 128'b01);
        n_stb[0] = 1'b0; step();
        chk("R4 hold stb low", {seen_stb, seen_ack}, {4'b0000, 2'b00});
        // R5: holder drops CYC; waiter served only one cycle later.
        n_cyc[0] = 1'b0; step();
        chk("R5 release cycle", 128'(seen_ack), 128'b00);
        step();
        chk("R5 next owner", {seen_stb, seen_ack}, {4'b1000, 2'b10});
        idle_all(); step();
        // R10: overlapping windows, lowest slave wins.
        hi[0] = 32'h0000_1FFF;
        req(1, 32'h0000_1800); step();
        chk("R10 overlap", {seen_stb, seen_ack}, {4'b0001, 2'b10});
        idle_all(); step();
        hi[0] = 32'h0000_0FFF; step();
        // Random traffic.
        for (int i = 0; i < 3000; i++) begin
            for (int m = 0; m < NM; m++) begin
                if (n_cyc[m] && $urandom % 8 == 0) begin
                    n_cyc[m] = 1'b0; n_stb[m] = 1'b0;
                end else if (!n_cyc[m] && $urandom % 3 == 0) begin
                    n_cyc[m] = 1'b1;
                end
                if (n_cyc[m]) n_stb[m] = ($urandom % 4) != 0;
                if ($urandom % 5 == 0) begin
                    int k = int'($urandom % NS);
                    case ($urandom % 6)
                        0: n_adr[m] = lo[k];
                        1: n_adr[m] = hi[k];
                        2: n_adr[m] = 32'h0000_4000 + ($urandom % 256);
                        default: n_adr[m] = $urandom & 32'h0000_3FFF;
                    endcase
                end
                n_we[m] = 1'($urandom); n_dat[m] = $urandom; n_sel[m] = 4'($urandom);
            end
            for (int k = 0; k < NS; k++) ack_en[k] = ($urandom % 4) != 0;
            step();
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule